// File: doc/BRIEF.md
# Command Activation Upper-Word Auto-Fill

This block lets software start a 64-bit command activation with a single 32-bit register write. It keeps a 32-bit upper-word register that software loads once. When the port runs in narrow-activation mode, a write to the low half of the activation register is joined at once with the held upper word. The block then issues one 64-bit activation event.

When narrow mode is off, the block waits for software to write both halves: first the low half, then the high half. The high-half write joins the two words and issues the event. The held upper word stays unchanged across any number of activations until software writes it again. The mode bit comes from a port control register outside the block. The block does not decode the activation contents.

Top module: `act_upper_fill`

## Requirements
- R1: After reset the held upper word reads as 0x0000_0000 and `actValid` is low.
- R2: A write at byte offset 0x01C stores all 32 bits of `busWData` as the held upper word. A read with `busAddr` = 0x01C returns that value on `busRData` in the same cycle.
- R3: With `wide32Mode` = 1, a write at the low-half offset 0x000 raises `actValid` in the cycle after the write. In that cycle `actData` is {held upper word, written data}, with the held word in bits 63:32.
- R4: `actValid` is high for exactly one cycle per activation. It is low in any cycle that does not directly follow a triggering write.
- R5: With `wide32Mode` = 0, a write at the low-half offset 0x000 produces no strobe on its own.
- R6: With `wide32Mode` = 0, a write at the high-half offset 0x004 that follows a low-half write raises `actValid` in the next cycle. `actData` is then {high-half data, stored low data}. The pairing is consumed, so a second high-half write produces no strobe.
- R7: A high-half write with no pending low-half write produces no strobe.
- R8: With `wide32Mode` = 0, a second low-half write before the high half replaces the stored low word.
- R9: The held upper word does not change when an activation fires or when the high half is written. Consecutive narrow-mode activations all use the same held word.
- R10: With `wide32Mode` = 1, a write at the high-half offset produces no strobe.
- R11: A read at any offset other than 0x01C returns zero on `busRData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 12 | Byte offset of the access |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for `busAddr` (combinational) |
| wide32Mode | input | 1 | Narrow-activation mode bit from port control |
| actValid | output | 1 | One-cycle activation strobe |
| actData | output | 64 | Full activation value, valid with `actValid` |

## Verification
Single low-half writes in narrow mode, with several different held upper words, show that the upper bits come from the register and not from the bus. Low-then-high pairs in wide mode show that both halves are joined in the right order. Orphan high writes, repeated low writes and high writes in narrow mode separate a correct pairing state from one that fires too often or keeps a stale low word. Rewriting the register between activations, and issuing activations without rewriting it, show that the held word changes only through a direct write.

// File: rtl/act_fill_pkg.sv
package act_fill_pkg;
  typedef struct packed {
    logic loadUpper;  // store bus data as held upper word
    logic latchLow;   // store bus data as pending low word
    logic fireFill;   // emit {held upper, bus data}
    logic firePair;   // emit {bus data, pending low}
  } fillStrobes_t;
endpackage

// File: rtl/act_fill_ctrl.sv
module act_fill_ctrl
  import act_fill_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UPPER_OFS = 12'h01C,
  parameter logic [ADDR_W-1:0] ACT_LO_OFS = 12'h000,
  parameter logic [ADDR_W-1:0] ACT_HI_OFS = 12'h004
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wide32Mode,
  output fillStrobes_t      strobes
);
  logic lowPending;
  logic hitUpper, hitLo, hitHi;

  assign hitUpper = busWrite && (busAddr == UPPER_OFS);
  assign hitLo    = busWrite && (busAddr == ACT_LO_OFS);
  assign hitHi    = busWrite && (busAddr == ACT_HI_OFS);

  always_comb begin
    strobes = '0;
    strobes.loadUpper = hitUpper;
    strobes.fireFill  = hitLo && wide32Mode;
    strobes.latchLow  = hitLo && !wide32Mode;
    strobes.firePair  = hitHi && !wide32Mode && lowPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowPending <= 1'b0;
    end else if (strobes.latchLow) begin
      lowPending <= 1'b1;
    end else if (strobes.fireFill || strobes.firePair) begin
      lowPending <= 1'b0;
    end
  end
endmodule

// File: rtl/act_fill_dp.sv
module act_fill_dp
  import act_fill_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UPPER_OFS = 12'h01C
) (
  input  logic                clk,
  input  logic                rstN,
  input  fillStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWData,
  output logic [DATA_W-1:0]   busRData,
  output logic                actValid,
  output logic [2*DATA_W-1:0] actData
);
  logic [DATA_W-1:0] upperReg;
  logic [DATA_W-1:0] lowHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperReg <= '0;
      lowHold  <= '0;
      actValid <= 1'b0;
      actData  <= '0;
    end else begin
      if (strobes.loadUpper) upperReg <= busWData;
      if (strobes.latchLow)  lowHold  <= busWData;
      actValid <= strobes.fireFill || strobes.firePair;
      if (strobes.fireFill)      actData <= {upperReg, busWData};
      else if (strobes.firePair) actData <= {busWData, lowHold};
    end
  end

  assign busRData = (busAddr == UPPER_OFS) ? upperReg : '0;
endmodule

// File: rtl/act_upper_fill.sv
module act_upper_fill
  import act_fill_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UPPER_OFS = 12'h01C,
  parameter logic [ADDR_W-1:0] ACT_LO_OFS = 12'h000,
  parameter logic [ADDR_W-1:0] ACT_HI_OFS = 12'h004
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWData,
  output logic [DATA_W-1:0]   busRData,
  input  logic                wide32Mode,
  output logic                actValid,
  output logic [2*DATA_W-1:0] actData
);
  fillStrobes_t strobes;

  act_fill_ctrl #(
    .ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS),
    .ACT_LO_OFS(ACT_LO_OFS), .ACT_HI_OFS(ACT_HI_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .wide32Mode(wide32Mode), .strobes(strobes)
  );

  act_fill_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData),
    .actValid(actValid), .actData(actData)
  );
endmodule

// File: rtl/act_upper_fill_chk.sv
module act_upper_fill_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UPPER_OFS = 12'h01C,
  parameter logic [ADDR_W-1:0] ACT_LO_OFS = 12'h000,
  parameter logic [ADDR_W-1:0] ACT_HI_OFS = 12'h004
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWData,
  input logic [DATA_W-1:0]   busRData,
  input logic                wide32Mode,
  input logic                actValid,
  input logic [2*DATA_W-1:0] actData
);
  // independent model of the held word, built from bus writes only
  logic [DATA_W-1:0] heldShadow;
  always_ff @(posedge clk) begin
    if (!rstN) heldShadow <= '0;
    else if (busWrite && busAddr == UPPER_OFS) heldShadow <= busWData;
  end

  assert_upper_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == UPPER_OFS) |-> (busRData == heldShadow));

  assert_narrow_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ACT_LO_OFS && wide32Mode) |=>
      (actValid && actData == {$past(heldShadow), $past(busWData)}));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> !actValid);

  assert_wide_low_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ACT_LO_OFS && !wide32Mode) |=> !actValid);

  assert_narrow_high_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ACT_HI_OFS && wide32Mode) |=> !actValid);

  assert_other_read_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != UPPER_OFS) |-> (busRData == '0));
endmodule

bind act_upper_fill act_upper_fill_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS),
  .ACT_LO_OFS(ACT_LO_OFS), .ACT_HI_OFS(ACT_HI_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .busWData(busWData), .busRData(busRData), .wide32Mode(wide32Mode),
  .actValid(actValid), .actData(actData)
);

// File: tb/act_upper_fill_test.sv
module act_upper_fill_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] UP_OFS = 12'h01C;
  localparam logic [11:0] LO_OFS = 12'h000;
  localparam logic [11:0] HI_OFS = 12'h004;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        wide32Mode = 1'b0;
  logic        actValid;
  logic [63:0] actData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  act_upper_fill uut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .wide32Mode(wide32Mode),
    .actValid(actValid), .actData(actData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one write cycle; returns at the negedge after the capturing edge
  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    busWrite = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 12'h0FC; busWData = '0;
  endtask

  task automatic readUpper(input string req, input logic [31:0] exp);
    busAddr = UP_OFS;
    #1;
    check(busRData == exp, req, {32'h0, busRData}, {32'h0, exp});
    busAddr = 12'h0FC;
  endtask

  task automatic expectStrobe(input string req, input logic [63:0] exp);
    check(actValid === 1'b1, req, {63'h0, actValid}, 64'h1);
    check(actData == exp, req, actData, exp);
  endtask

  task automatic expectQuiet(input string req);
    check(actValid === 1'b0, req, {63'h0, actValid}, 64'h0);
  endtask

  task automatic testReset;
    expectQuiet("R1");
    readUpper("R1", 32'h0);
  endtask

  task automatic testUpperRw;
    busWr(UP_OFS, 32'hA5C3_0F81);
    expectQuiet("R2");
    readUpper("R2", 32'hA5C3_0F81);
  endtask

  task automatic testNarrowFill;
    wide32Mode = 1'b1;
    busWr(UP_OFS, 32'h1234_5678);
    busWr(LO_OFS, 32'hDEAD_0001);
    expectStrobe("R3", 64'h1234_5678_DEAD_0001);
    @(negedge clk);
    expectQuiet("R4");
    busWr(UP_OFS, 32'hFFFF_0000);
    busWr(LO_OFS, 32'h0000_FFFF);
    expectStrobe("R3", 64'hFFFF_0000_0000_FFFF);
    @(negedge clk);
    expectQuiet("R4");
  endtask

  task automatic testPersist;
    wide32Mode = 1'b1;
    busWr(UP_OFS, 32'h0BAD_F00D);
    busWr(LO_OFS, 32'h0000_0011);
    expectStrobe("R9", 64'h0BAD_F00D_0000_0011);
    busWr(LO_OFS, 32'h0000_0022);
    expectStrobe("R9", 64'h0BAD_F00D_0000_0022);
    readUpper("R9", 32'h0BAD_F00D);
    wide32Mode = 1'b0;
    busWr(LO_OFS, 32'h0000_0033);
    busWr(HI_OFS, 32'h7777_7777);
    expectStrobe("R6", 64'h7777_7777_0000_0033);
    readUpper("R9", 32'h0BAD_F00D);
  endtask

  task automatic testWidePair;
    wide32Mode = 1'b0;
    busWr(UP_OFS, 32'hCCCC_CCCC);
    busWr(LO_OFS, 32'h4444_5555);
    expectQuiet("R5");
    @(negedge clk);
    expectQuiet("R5");
    busWr(HI_OFS, 32'h9999_8888);
    expectStrobe("R6", 64'h9999_8888_4444_5555);
    @(negedge clk);
    expectQuiet("R4");
    busWr(HI_OFS, 32'h1111_1111);
    expectQuiet("R6");
  endtask

  task automatic testOrphanHigh;
    wide32Mode = 1'b0;
    busWr(HI_OFS, 32'h2222_2222);
    expectQuiet("R7");
    @(negedge clk);
    expectQuiet("R7");
  endtask

  task automatic testReplaceLow;
    wide32Mode = 1'b0;
    busWr(LO_OFS, 32'hAAAA_0001);
    busWr(LO_OFS, 32'hBBBB_0002);
    expectQuiet("R8");
    busWr(HI_OFS, 32'h3030_3030);
    expectStrobe("R8", 64'h3030_3030_BBBB_0002);
  endtask

  task automatic testNarrowHigh;
    wide32Mode = 1'b1;
    busWr(HI_OFS, 32'h5A5A_5A5A);
    expectQuiet("R10");
    readUpper("R10", 32'hCCCC_CCCC);
  endtask

  task automatic testOtherRead;
    busAddr = LO_OFS; #1;
    check(busRData == 32'h0, "R11", {32'h0, busRData}, 64'h0);
    busAddr = HI_OFS; #1;
    check(busRData == 32'h0, "R11", {32'h0, busRData}, 64'h0);
    busAddr = 12'h018; #1;
    check(busRData == 32'h0, "R11", {32'h0, busRData}, 64'h0);
    busAddr = 12'h0FC;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUpperRw();
    testNarrowFill();
    testPersist();
    testWidePair();
    testOrphanHigh();
    testReplaceLow();
    testNarrowHigh();
    testOtherRead();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule